// File: doc/BRIEF.md
# Eight-Register 64-bit Mixing Executor

This block runs a short program of mixing instructions over a file of eight 64-bit registers. Each instruction names an operation, a destination register, a source register, an 8-bit modifier and a 32-bit immediate. Software or a neighbouring block writes the program into a local instruction store. It then gives an item number and a program length and pulses start. The executor first fills all eight registers from a seed built from the item number. It then executes the stored entries one after another, from address 0 up to the given length. When the last entry has been executed it raises done, and the eight register values stay visible on a flat output bus.

Multiplication results are produced by a wide combinational multiplier inside a two-cycle fetch/execute step. The value that the reciprocal-multiply operation uses is not computed here. It is taken from an input port and must be held stable for the whole run.

Top module: `mix_exec`

## Requirements
- R1: After reset, done_o and busy_o are 0 and all eight registers on regs_o read 0.
- R2: On start, the registers are seeded: r0 = (item_i + 1) * 6364136223846793005 mod 2^64, and rk = r0 xor Kk for k = 1..7 with K1 = 9298411001130361340, K2 = 12065312585734608966, K3 = 9306329213124626780, K4 = 5281919268842080866, K5 = 10536153434571861004, K6 = 3398623926847679864, K7 = 9549104520008361294. With a length of 0, done follows with only the seed applied.
- R3: An instruction word is {op[49:46], dst[45:43], src[42:40], mod[39:32], imm[31:0]}; op 0 sets dst = dst - src and op 1 sets dst = dst xor src.
- R4: Op 2 sets dst = dst + (src << s), where s is mod bits 3:2 (0 to 3); the other mod bits have no effect.
- R5: Op 3 sets dst to the low 64 bits of dst * src, and op 13 sets dst to the low 64 bits of dst * recip_i.
- R6: Op 4 rotates dst right by imm[5:0] places (nonzero counts 1 to 63).
- R7: Ops 5, 7 and 9 add, and ops 6, 8 and 10 xor, the immediate sign-extended from 32 to 64 bits into dst.
- R8: Op 11 sets dst to the upper 64 bits of the unsigned 128-bit product dst * src.
- R9: Op 12 sets dst to the upper 64 bits of the signed 128-bit product dst * src.
- R10: When src equals dst for a register operation, the operand is the destination's own current value.
- R11: Entries execute in address order; only entries 0 to len_i-1 run; done_o rises after the last one and busy_o is 1 from start until then; each instruction changes only its destination register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| prog_we_i | input | 1 | Instruction store write enable |
| prog_addr_i | input | 9 | Instruction store write address |
| prog_data_i | input | 50 | Instruction word to write |
| start_i | input | 1 | One-cycle pulse to seed and run |
| item_i | input | 64 | Item number used for the seed |
| len_i | input | 10 | Number of entries to execute |
| recip_i | input | 64 | Multiplier for the reciprocal-multiply operation |
| busy_o | output | 1 | Seeding or executing |
| done_o | output | 1 | Program finished, held until the next start |
| regs_o | output | 512 | Register k at bits 64k+63:64k |

## Verification
The bench goes after the seed wrap at item 2^64-1, where r0 becomes 0 and every other register equals its bare constant. A design that dropped the +1 or used the wrong constant order would show the wrong seed there. Signed high multiplies are driven with all four sign combinations, so a missing correction term shows up as an off-by-operand result. Add-shifted uses mod values that have bits outside 3:2 set, which exposes decoding of the wrong field. Negative immediates expose zero-extension, and a src-equals-dst subtract and xor that must give zero exposes a stale operand read. A stored entry just beyond the run length must leave the registers untouched, which catches an off-by-one end test.

// File: rtl/mix_pkg.sv
package mix_pkg;
  localparam int XLEN = 64;
  localparam int NREG = 8;
  localparam int RIW  = $clog2(NREG);
  localparam int IW   = 4 + 2 * RIW + 8 + 32;
  localparam logic [63:0] SEED_MUL = 64'd6364136223846793005;

  typedef struct packed {
    logic [3:0]     op;
    logic [RIW-1:0] dst;
    logic [RIW-1:0] src;
    logic [7:0]     mod;
    logic [31:0]    imm;
  } mix_ins_t;

  function automatic logic [63:0] seed_key(input int unsigned k);
    case (k)
      1: return 64'd9298411001130361340;
      2: return 64'd12065312585734608966;
      3: return 64'd9306329213124626780;
      4: return 64'd5281919268842080866;
      5: return 64'd10536153434571861004;
      6: return 64'd3398623926847679864;
      7: return 64'd9549104520008361294;
      default: return 64'd0;
    endcase
  endfunction

  function automatic logic [63:0] sext32(input logic [31:0] v);
    return {{32{v[31]}}, v};
  endfunction

  function automatic logic [63:0] ror64(input logic [63:0] x, input logic [5:0] n);
    return (x >> n) | (x << (7'd64 - {1'b0, n}));
  endfunction

  function automatic logic [63:0] mul_hi_u(input logic [63:0] a, input logic [63:0] b);
    logic [127:0] p;
    p = {64'd0, a} * {64'd0, b};
    return p[127:64];
  endfunction

  function automatic logic [63:0] mul_hi_s(input logic [63:0] a, input logic [63:0] b);
    logic [63:0] h;
    h = mul_hi_u(a, b);
    if (a[63]) h = h - b;
    if (b[63]) h = h - a;
    return h;
  endfunction
endpackage

// File: rtl/mix_imem.sv
module mix_imem #(
  parameter int DEPTH = 512,
  parameter int WIDTH = 50,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we_i,
  input  logic [AW-1:0]    waddr_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic [AW-1:0]    raddr_i,
  output logic [WIDTH-1:0] rdata_o
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we_i) mem[waddr_i] <= wdata_i;
    rdata_o <= mem[raddr_i];
  end
endmodule

// File: rtl/mix_alu.sv
module mix_alu
  import mix_pkg::*;
(
  input  mix_ins_t   ins_i,
  input  logic [63:0] dval_i,
  input  logic [63:0] sval_i,
  input  logic [63:0] recip_i,
  output logic [63:0] res_o
);
  logic [63:0] simm;
  assign simm = sext32(ins_i.imm);

  always_comb begin
    unique case (ins_i.op)
      4'd0:  res_o = dval_i - sval_i;
      4'd1:  res_o = dval_i ^ sval_i;
      4'd2:  res_o = dval_i + (sval_i << ins_i.mod[3:2]);
      4'd3:  res_o = dval_i * sval_i;
      4'd4:  res_o = ror64(dval_i, ins_i.imm[5:0]);
      4'd5, 4'd7, 4'd9:  res_o = dval_i + simm;
      4'd6, 4'd8, 4'd10: res_o = dval_i ^ simm;
      4'd11: res_o = mul_hi_u(dval_i, sval_i);
      4'd12: res_o = mul_hi_s(dval_i, sval_i);
      4'd13: res_o = dval_i * recip_i;
      default: res_o = dval_i;
    endcase
  end
endmodule

// File: rtl/mix_exec.sv
module mix_exec
  import mix_pkg::*;
#(
  parameter int DEPTH = 512,
  localparam int AW = $clog2(DEPTH),
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 prog_we_i,
  input  logic [AW-1:0]        prog_addr_i,
  input  logic [IW-1:0]        prog_data_i,
  input  logic                 start_i,
  input  logic [63:0]          item_i,
  input  logic [LW-1:0]        len_i,
  input  logic [63:0]          recip_i,
  output logic                 busy_o,
  output logic                 done_o,
  output logic [NREG*XLEN-1:0] regs_o
);
  typedef enum logic [2:0] {S_IDLE, S_SEED, S_FETCH, S_EXEC, S_DONE} st_t;

  st_t         state;
  logic [AW:0] pc;
  logic [LW-1:0] len_q;
  logic [63:0] item_q;
  logic [63:0] rf [NREG];
  logic [IW-1:0] rdata;
  mix_ins_t    ins;
  logic [63:0] alu_res;

  // named events for checking
  logic        seed_load;
  logic        wr_en;
  logic [RIW-1:0] wr_idx;
  logic        last_ins;
  logic [63:0] seed_base;

  assign ins       = mix_ins_t'(rdata);
  assign seed_load = (state == S_SEED);
  assign wr_en     = (state == S_EXEC);
  assign wr_idx    = ins.dst;
  assign last_ins  = ({{(LW-AW-1){1'b0}}, pc} + 1'b1) >= {1'b0, len_q};
  assign seed_base = (item_q + 64'd1) * SEED_MUL;

  mix_imem #(.DEPTH(DEPTH), .WIDTH(IW)) imem_i (
    .clk(clk), .we_i(prog_we_i), .waddr_i(prog_addr_i), .wdata_i(prog_data_i),
    .raddr_i(pc[AW-1:0]), .rdata_o(rdata)
  );

  mix_alu alu_i (
    .ins_i(ins), .dval_i(rf[ins.dst]), .sval_i(rf[ins.src]),
    .recip_i(recip_i), .res_o(alu_res)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      pc     <= '0;
      len_q  <= '0;
      item_q <= '0;
    end else begin
      unique case (state)
        S_IDLE, S_DONE: if (start_i) begin
          state  <= S_SEED;
          item_q <= item_i;
          len_q  <= len_i;
        end
        S_SEED: begin
          pc    <= '0;
          state <= (len_q == '0) ? S_DONE : S_FETCH;
        end
        S_FETCH: state <= S_EXEC;
        S_EXEC: begin
          pc    <= pc + 1'b1;
          state <= last_ins ? S_DONE : S_FETCH;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  for (genvar k = 0; k < NREG; k++) begin : g_rf
    always_ff @(posedge clk) begin
      if (!rst_n) rf[k] <= '0;
      else if (seed_load) rf[k] <= seed_base ^ seed_key(k);
      else if (wr_en && wr_idx == RIW'(k)) rf[k] <= alu_res;
    end
    assign regs_o[k*XLEN +: XLEN] = rf[k];
  end

  assign busy_o = (state == S_SEED) || (state == S_FETCH) || (state == S_EXEC);
  assign done_o = (state == S_DONE);

  AST_PC_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> ({{(LW-AW-1){1'b0}}, pc} < {1'b0, len_q}));  // R11
  AST_SEED_CHAIN: assert property (@(posedge clk) disable iff (!rst_n)
    seed_load |=> (rf[3] == (rf[0] ^ seed_key(3))));  // R2
  AST_QUIET_REGS: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !seed_load) |=> $stable(regs_o));  // R11
  AST_ONLY_DST: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx != '0) |=> $stable(rf[0]));  // R11
  AST_DONE_ORIGIN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> ($past(state) == S_EXEC || $past(state) == S_SEED));  // R11
endmodule

// File: tb/mix_exec_tb.sv
module mix_exec_tb_top;
  logic clk = 0;
  logic rst_n = 0;
  logic prog_we = 0;
  logic [8:0] prog_addr = 0;
  logic [49:0] prog_data = 0;
  logic start = 0;
  logic [63:0] item = 0;
  logic [9:0] len = 0;
  logic [63:0] recip = 0;
  logic busy, done;
  logic [511:0] regs;

  int n_tests = 0, n_fail = 0;
  logic [63:0] m [8];
  logic [49:0] prog [16];
  int nprog;

  always #2.5 clk = ~clk;

  mix_exec dut_i (
    .clk(clk), .rst_n(rst_n), .prog_we_i(prog_we), .prog_addr_i(prog_addr),
    .prog_data_i(prog_data), .start_i(start), .item_i(item), .len_i(len),
    .recip_i(recip), .busy_o(busy), .done_o(done), .regs_o(regs)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] hu(input logic [63:0] a, input logic [63:0] b);
    logic [63:0] ll, lh, hl, hh, mid;
    ll = a[31:0] * b[31:0]; lh = a[31:0] * b[63:32];
    hl = a[63:32] * b[31:0]; hh = a[63:32] * b[63:32];
    mid = {32'd0, ll[63:32]} + {32'd0, lh[31:0]} + {32'd0, hl[31:0]};
    return hh + {32'd0, lh[63:32]} + {32'd0, hl[63:32]} + {32'd0, mid[63:32]};
  endfunction

  function automatic logic [63:0] hs(input logic [63:0] a, input logic [63:0] b);
    logic signed [127:0] p;
    p = $signed({{64{a[63]}}, a}) * $signed({{64{b[63]}}, b});
    return p[127:64];
  endfunction

  function automatic logic [63:0] key(input int k);
    logic [63:0] t [8];
    t[0] = 0; t[1] = 64'd9298411001130361340; t[2] = 64'd12065312585734608966;
    t[3] = 64'd9306329213124626780; t[4] = 64'd5281919268842080866;
    t[5] = 64'd10536153434571861004; t[6] = 64'd3398623926847679864;
    t[7] = 64'd9549104520008361294;
    return t[k];
  endfunction

  task automatic put(input int op, input int d, input int s, input int md, input logic [31:0] im);
    prog[nprog] = {op[3:0], d[2:0], s[2:0], md[7:0], im};
    @(negedge clk);
    prog_we = 1; prog_addr = nprog[8:0]; prog_data = prog[nprog];
    @(negedge clk);
    prog_we = 0;
    nprog++;
  endtask

  task automatic model(input logic [63:0] it, input int n);
    logic [63:0] r0, dv, sv, x;
    logic [127:0] rr;
    r0 = (it + 1) * 64'd6364136223846793005;
    for (int k = 0; k < 8; k++) m[k] = r0 ^ key(k);
    for (int i = 0; i < n; i++) begin
      logic [3:0] op; logic [2:0] d, s; logic [7:0] md; logic [31:0] im;
      {op, d, s, md, im} = prog[i];
      dv = m[d]; sv = m[s];
      x = {{32{im[31]}}, im};
      case (op)
        0: m[d] = dv + (~sv + 1);
        1: m[d] = dv ^ sv;
        2: m[d] = dv + sv * (64'd1 << md[3:2]);
        3: m[d] = dv * sv;
        4: begin rr = {dv, dv} >> im[5:0]; m[d] = rr[63:0]; end
        5, 7, 9: m[d] = dv + x;
        6, 8, 10: m[d] = dv ^ x;
        11: m[d] = hu(dv, sv);
        12: m[d] = hs(dv, sv);
        13: m[d] = dv * recip;
        default: ;
      endcase
    end
  endtask

  task automatic run(input string tag, input logic [63:0] it, input int n, input int model_n);
    int w = 0;
    @(negedge clk);
    item = it; len = n[9:0]; start = 1;
    @(negedge clk);
    start = 0;
    chk(busy === 1'b1, {tag, " R11 busy"}, {63'd0, busy}, 64'd1);
    while (!done && w < 5000) begin @(negedge clk); w++; end
    chk(done === 1'b1, {tag, " R11 done"}, {63'd0, done}, 64'd1);
    model(it, model_n);
    for (int k = 0; k < 8; k++)
      chk(regs[k*64 +: 64] === m[k], $sformatf("%s reg%0d", tag, k), regs[k*64 +: 64], m[k]);
  endtask

  task automatic t_reset;
    chk(done === 0 && busy === 0, "R1 flags", {62'd0, busy, done}, 0);
    for (int k = 0; k < 8; k++) chk(regs[k*64 +: 64] === 0, "R1 reg zero", regs[k*64 +: 64], 0);
  endtask

  task automatic t_seed;
    nprog = 0;
    run("R2 seed item 0", 64'd0, 0, 0);
    run("R2 seed item 12345", 64'd12345, 0, 0);
    run("R2 seed wrap", 64'hFFFF_FFFF_FFFF_FFFF, 0, 0);
    chk(regs[63:0] === 0, "R2 wrap r0", regs[63:0], 0);
  endtask

  task automatic t_regops;
    nprog = 0;
    put(0, 1, 2, 0, 0); put(1, 3, 4, 0, 0);
    put(0, 5, 5, 0, 0); put(1, 6, 6, 0, 0);
    run("R3 R10 regops", 64'd5, nprog, nprog);
    chk(regs[5*64 +: 64] === 0, "R10 sub self", regs[5*64 +: 64], 0);
  endtask

  task automatic t_addshift;
    nprog = 0;
    put(2, 0, 1, 8'h00, 0); put(2, 2, 3, 8'h04, 0);
    put(2, 4, 5, 8'h08, 0); put(2, 6, 7, 8'h0C, 0);
    put(2, 1, 2, 8'hF3, 0); put(2, 3, 3, 8'h0C, 0);
    run("R4 R10 addshift", 64'd77, nprog, nprog);
  endtask

  task automatic t_mul;
    nprog = 0; recip = 64'hD6F2_0A3B_9911_0457;
    put(3, 0, 1, 0, 0); put(13, 2, 0, 0, 0); put(3, 4, 4, 0, 0); put(13, 7, 7, 0, 0);
    run("R5 mul", 64'd901, nprog, nprog);
  endtask

  task automatic t_ror;
    nprog = 0;
    put(4, 0, 0, 0, 1); put(4, 1, 0, 0, 63); put(4, 2, 0, 0, 32); put(4, 3, 0, 0, 17);
    run("R6 ror", 64'd3, nprog, nprog);
  endtask

  task automatic t_imm;
    nprog = 0;
    put(5, 0, 0, 0, 32'hFFFF_FFF0); put(6, 1, 0, 0, 32'h8000_0001);
    put(7, 2, 0, 0, 32'h1234_5678); put(8, 3, 0, 0, 32'h7FFF_FFFF);
    put(9, 4, 0, 0, 32'h8000_0000); put(10, 5, 0, 0, 32'hFFFF_FFFF);
    run("R7 imm", 64'd44, nprog, nprog);
  endtask

  task automatic t_mulh;
    nprog = 0;
    put(11, 0, 1, 0, 0); put(11, 2, 2, 0, 0);
    put(12, 3, 4, 0, 0); put(12, 5, 6, 0, 0);
    put(12, 7, 1, 0, 0); put(12, 4, 4, 0, 0);
    put(11, 6, 3, 0, 0);
    for (int it = 0; it < 4; it++) run($sformatf("R8 R9 mulh it%0d", it), 64'(it * 1000 + 17), nprog, nprog);
  endtask

  task automatic t_len;
    nprog = 0;
    put(5, 0, 0, 0, 32'd1); put(6, 1, 0, 0, 32'd2); put(1, 2, 3, 0, 0);
    run("R11 len 2 extra ignored", 64'd9, 2, 2);
    run("R11 full length", 64'd9, 3, 3);
  endtask

  initial begin
    #(5ns * 150000);
    n_fail++; n_tests++;
    $display("FAIL watchdog R11 actual=%h expected=%h", 64'd0, 64'd1);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_seed; t_regops; t_addshift; t_mul; t_ror; t_imm; t_mulh; t_len;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule